// File: doc/BRIEF.md
# Multichannel CIC Interpolator with Split Output Buses

This block is a cascaded integrator-comb interpolator for several channels that share one input stream in turn. One input handshake carries one sample per beat, with channels arriving in ascending order. A bank of comb stages processes each sample. The comb stages keep separate delay storage for every channel. The comb results for one whole channel cycle are held until every channel has arrived. Then the block starts a burst of `RATE` output phases. Channel `k` leaves on output bus `k mod NUM_IF`. Each bus carries `NUM_CH/NUM_IF` channels, interleaved in turn.

Every output bus has its own chain of integrator stages, with one accumulator per channel on that bus. During the first phase of a burst the integrators take the held comb value. During the other `RATE-1` phases they take zero, which is the zero-stuffing step. Arithmetic wraps in two's complement at the full internal width `IN_W + STAGES*ceil(log2(RATE*DDELAY))`. At that width the result is exact, with no rounding and no saturation. All output buses advance together, one beat at a time. The input stays closed until the burst is finished.

Elaboration stops when the channel count is not a whole multiple of the bus count. A user in that position pads the stream with dummy channels. Elaboration also stops when more than one bus is configured with a rate below the bus count. With one bus, every channel leaves in turn on that single bus.

Top module: `cic_interp_split`

## Requirements
- R1: After reset, `in_ready` is 1 and every `out_valid` bit is 0. All comb delays and integrator accumulators are zero, and the input channel counter is at channel 0.
- R2: Input channel `k` (0-based, in order of arrival within a channel cycle) leaves on bus `k mod NUM_IF`, in slot `k / NUM_IF` of that bus's packet.
- R3: Each completed channel cycle produces exactly `RATE*(NUM_CH/NUM_IF)` beats on every bus. The beats run phase by phase, and within one phase they run slot 0 first. All `out_valid` bits are equal. `in_ready` rises again in the cycle after the last beat is taken.
- R4: On each bus, `out_sop` is 1 exactly on slot 0 and `out_eop` is 1 exactly on the last slot. Every phase therefore forms one packet that holds one sample per channel on that bus.
- R5: `in_ready` falls in the cycle after the input accepts channel `NUM_CH-1`. It stays 0 while the buses emit the burst. Input beats offered while `in_ready` is 0 are not taken.
- R6: Each output sample equals the per-channel response of a comb section (`STAGES` stages, differential delay `DDELAY`) followed by upsampling by `RATE` with inserted zeros, then `STAGES` integrators. The result is taken modulo 2^`ACC_W`, and the state of each channel is independent of every other channel.
- R7: A beat completes only when every bit of `out_ready` is 1. While any bit is 0, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values.
- R8: An accepted input beat with `in_sop` = 1 is treated as channel 0, whatever the counter held. Counting then resumes from channel 1.
- R9: `in_eop` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample can be taken |
| in_data | input | IN_W | Signed input sample of the current channel |
| in_sop | input | 1 | Marks channel 0 of a channel cycle |
| in_eop | input | 1 | Marks the last channel; ignored |
| out_valid | output | NUM_IF | Per-bus output sample valid |
| out_ready | input | NUM_IF | Per-bus sink ready |
| out_data | output | NUM_IF*ACC_W | Bus `i` in bits `[i*ACC_W +: ACC_W]`, signed full width |
| out_sop | output | NUM_IF | First slot of a phase on bus `i` |
| out_eop | output | NUM_IF | Last slot of a phase on bus `i` |

## Verification
The bench sends an impulse on channel 0 together with a small value on channel 5. It then drives sustained full-scale positive and negative values on alternating channels, which shows crosstalk or a wrong bus mapping as a wrong sample on the wrong bus. If the wrap or the bit growth is handled wrongly, the DC steps show it as a corrupted plateau. Random gaps in `in_valid` and in each `out_ready` bit check that a stalled beat holds still and that the input stays closed through the whole burst. A design that advanced on a partial `out_ready`, or that reopened the input early, would lose samples or duplicate them. One channel cycle is cut short by an early `in_sop`, and `in_eop` is toggled at random. A design that ignored the realignment would send every later sample to the wrong slot.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Index width that never collapses to zero bits.
    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Full internal width: input width plus worst-case growth of the filter.
    function automatic int acc_width(input int in_w, input int stages,
                                     input int rate, input int ddelay);
        return in_w + stages * $clog2(rate * ddelay);
    endfunction

endpackage

// File: rtl/cic_comb_bank.sv
// Comb section shared by all channels; delay storage is kept per channel.
module cic_comb_bank #(
    parameter int NUM_CH = 8,
    parameter int STAGES = 3,
    parameter int DDELAY = 1,
    parameter int W      = 25,
    parameter int CW     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [CW-1:0] ch,
    input  logic [W-1:0]  x,
    output logic [W-1:0]  y
);
    logic [W-1:0] dly_d [STAGES][DDELAY][NUM_CH];
    logic [W-1:0] dly_q [STAGES][DDELAY][NUM_CH];
    logic [W-1:0] stage_v;
    logic [W-1:0] oldest;

    always_comb begin
        dly_d   = dly_q;
        stage_v = x;
        oldest  = '0;
        for (int s = 0; s < STAGES; s++) begin
            oldest = dly_q[s][DDELAY-1][ch];
            if (en) begin
                for (int m = DDELAY - 1; m > 0; m--) begin
                    dly_d[s][m][ch] = dly_q[s][m-1][ch];
                end
                dly_d[s][0][ch] = stage_v;
            end
            stage_v = stage_v - oldest;
        end
        y = stage_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '{default: '0};
        end else begin
            dly_q <= dly_d;
        end
    end
endmodule

// File: rtl/cic_integ_lane.sv
// Integrator chain of one output bus, one accumulator per channel slot.
module cic_integ_lane #(
    parameter int SLOTS  = 2,
    parameter int STAGES = 3,
    parameter int W      = 25,
    parameter int SW     = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [SW-1:0] slot,
    input  logic [W-1:0]  x,
    output logic [W-1:0]  y
);
    logic [W-1:0] acc_d [STAGES][SLOTS];
    logic [W-1:0] acc_q [STAGES][SLOTS];
    logic [W-1:0] run_v;

    always_comb begin
        acc_d = acc_q;
        run_v = x;
        for (int s = 0; s < STAGES; s++) begin
            run_v = acc_q[s][slot] + run_v;
            if (adv) begin
                acc_d[s][slot] = run_v;
            end
        end
        y = run_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '{default: '0};
        end else begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/cic_interp_split.sv
module cic_interp_split #(
    parameter int NUM_CH = 8,
    parameter int NUM_IF = 4,
    parameter int RATE   = 8,
    parameter int STAGES = 3,
    parameter int DDELAY = 1,
    parameter int IN_W   = 16,
    localparam int ACC_W = cic_pkg::acc_width(IN_W, STAGES, RATE, DDELAY)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [IN_W-1:0]         in_data,
    input  logic                    in_sop,
    input  logic                    in_eop,
    output logic [NUM_IF-1:0]       out_valid,
    input  logic [NUM_IF-1:0]       out_ready,
    output logic [NUM_IF*ACC_W-1:0] out_data,
    output logic [NUM_IF-1:0]       out_sop,
    output logic [NUM_IF-1:0]       out_eop
);
    localparam int SLOTS = NUM_CH / NUM_IF;
    localparam int CW    = cic_pkg::bits_for(NUM_CH);
    localparam int PW    = cic_pkg::bits_for(RATE);
    localparam int SW    = cic_pkg::bits_for(SLOTS);

    if (NUM_CH % NUM_IF != 0) begin : g_bad_split
        $error("channel count must be a multiple of the output bus count");
    end
    if (NUM_IF > 1 && RATE < NUM_IF) begin : g_bad_rate
        $error("rate change must be at least the output bus count");
    end

    typedef struct packed {
        logic          emit;
        logic [CW-1:0] cnt;
        logic [PW-1:0] phase;
        logic [SW-1:0] slot;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [ACC_W-1:0] hold_d [NUM_CH];
    logic [ACC_W-1:0] hold_q [NUM_CH];
    logic [ACC_W-1:0] comb_y;
    logic [ACC_W-1:0] in_ext;
    logic [CW-1:0]    ch_idx;
    logic             in_fire;
    logic             out_fire;
    logic             last_ch;
    logic [ACC_W-1:0] lane_y [NUM_IF];

    assign in_ext   = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};
    assign ch_idx   = in_sop ? '0 : ctl_q.cnt;
    assign in_ready = !ctl_q.emit;
    assign in_fire  = in_valid && !ctl_q.emit;
    assign out_fire = ctl_q.emit && (&out_ready);
    assign last_ch  = (ch_idx == CW'(NUM_CH - 1));

    cic_comb_bank #(
        .NUM_CH(NUM_CH), .STAGES(STAGES), .DDELAY(DDELAY), .W(ACC_W), .CW(CW)
    ) u_comb (
        .clk(clk), .rst_n(rst_n), .en(in_fire), .ch(ch_idx), .x(in_ext), .y(comb_y)
    );

    for (genvar i = 0; i < NUM_IF; i++) begin : g_lane
        logic [ACC_W-1:0] lane_x;

        // R2: bus i serves channels i, i+NUM_IF, ... in slot order
        always_comb begin
            lane_x = '0;
            if (ctl_q.phase == '0) begin
                lane_x = hold_q[int'(ctl_q.slot) * NUM_IF + i];
            end
        end

        cic_integ_lane #(
            .SLOTS(SLOTS), .STAGES(STAGES), .W(ACC_W), .SW(SW)
        ) u_integ (
            .clk(clk), .rst_n(rst_n), .adv(out_fire), .slot(ctl_q.slot),
            .x(lane_x), .y(lane_y[i])
        );

        assign out_data[i*ACC_W +: ACC_W] = lane_y[i];
        assign out_valid[i] = ctl_q.emit;
        assign out_sop[i]   = ctl_q.emit && (ctl_q.slot == '0);
        assign out_eop[i]   = ctl_q.emit && (ctl_q.slot == SW'(SLOTS - 1));
    end

    always_comb begin
        ctl_d  = ctl_q;
        hold_d = hold_q;
        if (in_fire) begin
            hold_d[ch_idx] = comb_y;
            if (last_ch) begin
                ctl_d.emit  = 1'b1;
                ctl_d.cnt   = '0;
                ctl_d.phase = '0;
                ctl_d.slot  = '0;
            end else begin
                ctl_d.cnt = ch_idx + 1'b1;
            end
        end
        if (out_fire) begin
            if (ctl_q.slot == SW'(SLOTS - 1)) begin
                ctl_d.slot = '0;
                if (ctl_q.phase == PW'(RATE - 1)) begin
                    ctl_d.phase = '0;
                    ctl_d.emit  = 1'b0;
                end else begin
                    ctl_d.phase = ctl_q.phase + 1'b1;
                end
            end else begin
                ctl_d.slot = ctl_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            hold_q <= '{default: '0};
        end else begin
            ctl_q  <= ctl_d;
            hold_q <= hold_d;
        end
    end

    AST_CLOSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && last_ch) |=> (!in_ready && out_valid[0])); // R5
    AST_READY_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid && in_ready)); // R5
    AST_REOPEN_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(out_valid[0] && (&out_ready) && out_eop[0])); // R3
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] && !(&out_ready)) |=> (out_valid[0] && $stable(out_data)
            && $stable(out_sop) && $stable(out_eop))); // R7
    AST_PACKET_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] && (&out_ready) && out_eop[0]) |=> (!out_valid[0] || out_sop[0])); // R4
    AST_BUSES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == '0) || (out_valid == '1)); // R3
endmodule

// File: tb/tb_cic_interp_split.sv
module tb_cic_interp_split;
    localparam int NCH = 8;
    localparam int NIF = 4;
    localparam int RT  = 8;
    localparam int STG = 3;
    localparam int DD  = 1;
    localparam int IW  = 16;
    localparam int W   = 25;   // 16 + 3*ceil(log2(8*1))
    localparam int CPI = NCH / NIF;
    localparam longint MASK = (longint'(1) << W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [IW-1:0]    in_data = '0;
    logic             in_sop = 1'b0;
    logic             in_eop = 1'b0;
    logic [NIF-1:0]   out_valid;
    logic [NIF-1:0]   out_ready = '0;
    logic [NIF*W-1:0] out_data;
    logic [NIF-1:0]   out_sop;
    logic [NIF-1:0]   out_eop;

    always #5 clk = ~clk;

    cic_interp_split #(
        .NUM_CH(NCH), .NUM_IF(NIF), .RATE(RT), .STAGES(STG), .DDELAY(DD), .IN_W(IW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    longint cd [STG][DD][NCH];
    longint acc [STG][NCH];
    longint hold [NCH];
    longint expq [$];
    int mcnt = 0;
    int mbeats = 0;
    int frames = 0;
    bit realigned = 1'b0;
    bit prev_stall = 1'b0;
    logic [NIF*W-1:0] stall_data;
    logic [NIF-1:0] stall_sop, stall_eop;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_in(input longint x0, input bit sop);
        int c;
        longint v, old, x;
        c = sop ? 0 : mcnt;
        v = x0 & MASK;
        for (int s = 0; s < STG; s++) begin
            old = cd[s][DD-1][c];
            for (int m = DD - 1; m > 0; m--) cd[s][m][c] = cd[s][m-1][c];
            cd[s][0][c] = v;
            v = (v - old) & MASK;
        end
        hold[c] = v;
        if (c == NCH - 1) begin
            mcnt = 0;
            frames++;
            for (int p = 0; p < RT; p++) begin
                for (int j = 0; j < CPI; j++) begin
                    for (int i = 0; i < NIF; i++) begin
                        int ch;
                        ch = j * NIF + i;
                        x = (p == 0) ? hold[ch] : 0;
                        for (int s = 0; s < STG; s++) begin
                            acc[s][ch] = (acc[s][ch] + x) & MASK;
                            x = acc[s][ch];
                        end
                        expq.push_back(x | (longint'(j == 0) << W) | (longint'(j == CPI - 1) << (W + 1)));
                    end
                end
            end
            mbeats = RT * CPI;
        end else begin
            mcnt = c + 1;
        end
    endtask

    function automatic logic [IW-1:0] stim(input int f, input int c);
        if (f == 0) return (c == 0) ? 16'd1000 : ((c == 5) ? 16'hFFF9 : 16'd0);
        if (f <= 5) return (c % 2 == 1) ? 16'h7FFF : 16'h8000;
        if (f <= 8) return 16'd0;
        return IW'($urandom);
    endfunction

    initial begin
        for (int s = 0; s < STG; s++)
            for (int c = 0; c < NCH; c++) begin
                acc[s][c] = 0;
                for (int m = 0; m < DD; m++) cd[s][m][c] = 0;
            end
        for (int c = 0; c < NCH; c++) hold[c] = 0;

        repeat (3) @(negedge clk);
        #1;
        chk(in_ready === 1'b1, "R1 in_ready during reset", longint'(in_ready), 1);
        chk(out_valid === '0, "R1 out_valid during reset", longint'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 6000 && frames < 40; cyc++) begin
            bit force_sop;
            bit exp_emit;
            // drive at the falling edge
            force_sop = 1'b0;
            if (frames == 12 && mcnt == 3 && !realigned) begin
                force_sop = 1'b1;   // R8: early start of a new channel cycle
                realigned = 1'b1;
            end
            in_valid  = (frames < 9) ? 1'b1 : (($urandom % 4) != 0);
            in_sop    = force_sop || (mcnt == 0);
            in_eop    = (frames < 9) ? (mcnt == NCH - 1) : 1'($urandom);   // R9
            in_data   = stim(frames, force_sop ? 0 : mcnt);
            for (int i = 0; i < NIF; i++)
                out_ready[i] = (frames < 9) ? 1'b1 : (($urandom % 5) != 0);
            #1;
            exp_emit = (mbeats > 0);
            chk(in_ready === !exp_emit, "R5 R8 in_ready", longint'(in_ready), longint'(!exp_emit));
            chk(out_valid === (exp_emit ? {NIF{1'b1}} : {NIF{1'b0}}), "R3 out_valid",
                longint'(out_valid), exp_emit ? longint'((1 << NIF) - 1) : 0);
            if (prev_stall && exp_emit) begin
                chk(out_data === stall_data && out_sop === stall_sop && out_eop === stall_eop,
                    "R7 stalled beat held", longint'(out_data[W-1:0]), longint'(stall_data[W-1:0]));
            end
            prev_stall = 1'b0;
            if (exp_emit && (&out_ready)) begin
                for (int i = 0; i < NIF; i++) begin
                    longint e;
                    e = expq.pop_front();
                    chk(longint'(out_data[i*W +: W]) == (e & MASK), "R2 R6 R9 data",
                        longint'(out_data[i*W +: W]), e & MASK);
                    chk(out_sop[i] === e[W], "R4 out_sop", longint'(out_sop[i]), longint'(e[W]));
                    chk(out_eop[i] === e[W+1], "R4 out_eop", longint'(out_eop[i]), longint'(e[W+1]));
                end
                mbeats--;
            end else if (exp_emit) begin
                prev_stall = 1'b1;
                stall_data = out_data;
                stall_sop  = out_sop;
                stall_eop  = out_eop;
            end
            if (!exp_emit && in_valid) begin
                model_in(longint'($signed(in_data)), in_sop);
            end
            @(negedge clk);
        end
        chk(frames >= 40, "R3 frames completed", frames, 40);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule